// File: doc/BRIEF.md
# Guard-Round-Sticky Mantissa Rounder

This block is the rounding stage of a floating-point datapath. A caller hands it an unpacked mantissa whose two lowest bits are the guard bit and the round bit. A sticky bit comes on its own pin. The caller also supplies the sign of the value and a two-bit rounding direction. One clock later the block returns the mantissa with the two extra bits dropped. If the rounding direction calls for it, that mantissa has been incremented by one at its least significant bit. The block also returns a flag that says whether the increment happened, and a flag that says whether any precision was lost.

The block does not correct the exponent, renormalise or pack the result. When the increment carries out of the top bit, the output holds the value 2.0: a one in the extra top bit and zeros below it. The output is left that way so that the caller can bump its exponent and shift. The mantissa width is a parameter.

Top module: `grs_rounder`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock edge earlier. While `rst_n` is low, `out_valid`, `out_mant`, `out_up` and `out_inexact` are all zero.
- R2: When guard (`in_mant[1]`), round (`in_mant[0]`) and `in_sticky` are all zero, the result is exact: `out_up` is 0, `out_inexact` is 0 and `out_mant` equals `in_mant >> 2`.
- R3: `out_inexact` is 1 exactly when at least one of guard, round or sticky is 1.
- R4: Mode 2'b00 (nearest, ties to even) rounds up only when guard is 1 and at least one of the following is 1: round, sticky, or the kept LSB `in_mant[2]`.
- R5: Mode 2'b01 (toward zero) never rounds up.
- R6: Mode 2'b10 (toward plus infinity) rounds up exactly when the result is inexact and `in_sign` is 0 (positive).
- R7: Mode 2'b11 (toward minus infinity) rounds up exactly when the result is inexact and `in_sign` is 1 (negative).
- R8: `out_mant` is MANT_W+1 bits wide and equals `in_mant[MANT_W+1:2] + out_up`, with the carry fully propagated. When the kept bits are all ones and the block rounds up, the output is 1 << MANT_W (the value 2.0), passed out unchanged.
- R9: `out_up` is 1 exactly when the increment was applied, and it is always 0 when `out_inexact` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand is present this cycle |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_mant | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_mode | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| out_valid | output | 1 | Registered result is present |
| out_mant | output | MANT_W+1 | Rounded mantissa; top bit is the carry (2.0) position |
| out_up | output | 1 | The increment was applied |
| out_inexact | output | 1 | Guard, round or sticky was set |

## Verification
Two events can happen in the same cycle: the rounding decision and a carry out of the whole mantissa. The bench provokes this with kept bits that are all ones. It uses a tie with an odd LSB in nearest mode, and any nonzero guard/round/sticky bits in the directed modes. It then judges both the rounding flag and the 2.0 pattern in the same output word. A second overlap comes from the tie-breaking rule. The bench pairs an exact tie with both an even and an odd kept LSB, so the outcome of the decision depends on the mantissa bits that the increment then changes. A behavioural model in the bench predicts every output, and the bench compares against it on every clock.

// File: rtl/grs_pkg.sv
package grs_pkg;

    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'b00,
        RMODE_ZERO    = 2'b01,
        RMODE_POS     = 2'b10,
        RMODE_NEG     = 2'b11
    } rmode_e;

endpackage

// File: rtl/grs_decide.sv
// Rounding decision: from the discarded bits, the kept LSB, the sign and
// the direction, choose whether to increment and whether precision was lost.
module grs_decide
    import grs_pkg::*;
(
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   round_i,
    input  logic   sticky_i,
    input  rmode_e mode_i,
    output logic   up_o,
    output logic   inexact_o
);

    logic lost;
    logic tie_break;

    always_comb begin
        lost      = guard_i | round_i | sticky_i;
        // Above the halfway point, or exactly halfway with an odd kept LSB.
        tie_break = round_i | sticky_i | lsb_i;
        up_o      = 1'b0;
        unique case (mode_i)
            RMODE_NEAREST: up_o = guard_i & tie_break;
            RMODE_ZERO:    up_o = 1'b0;
            RMODE_POS:     up_o = lost & ~sign_i;
            RMODE_NEG:     up_o = lost & sign_i;
            default:       up_o = 1'b0;
        endcase
        inexact_o = lost;
    end

endmodule

// File: rtl/grs_incr.sv
// Conditional +1 built as an explicit carry chain. The carry-out is kept
// as the top bit of the result so that 2.0 is visible.
module grs_incr #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             inc_i,
    output logic [WIDTH:0]   sum_o
);

    logic [WIDTH:0] carry;

    assign carry[0] = inc_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]    = a_i[i] ^ carry[i];
        assign carry[i+1]  = a_i[i] & carry[i];
    end

    assign sum_o[WIDTH] = carry[WIDTH];

endmodule

// File: rtl/grs_rounder.sv
module grs_rounder
    import grs_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [MANT_W+1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [MANT_W:0]   out_mant,
    output logic              out_up,
    output logic              out_inexact
);

    localparam int IN_W  = MANT_W + 2;
    localparam int OUT_W = MANT_W + 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] mant;
        logic             up;
        logic             inexact;
    } stage_t;

    stage_t st_d, st_q;

    logic [MANT_W-1:0] kept;
    logic [OUT_W-1:0]  incd;
    logic              dec_up;
    logic              dec_inexact;

    assign kept = in_mant[IN_W-1:2];

    grs_decide u_decide (
        .sign_i    (in_sign),
        .lsb_i     (in_mant[2]),
        .guard_i   (in_mant[1]),
        .round_i   (in_mant[0]),
        .sticky_i  (in_sticky),
        .mode_i    (rmode_e'(in_mode)),
        .up_o      (dec_up),
        .inexact_o (dec_inexact)
    );

    grs_incr #(.WIDTH(MANT_W)) u_incr (
        .a_i   (kept),
        .inc_i (dec_up),
        .sum_o (incd)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.mant    = incd;
            st_d.up      = dec_up;
            st_d.inexact = dec_inexact;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_mant    = st_q.mant;
    assign out_up      = st_q.up;
    assign out_inexact = st_q.inexact;

endmodule

// File: rtl/grs_rounder_chk.sv
module grs_rounder_chk #(
    parameter int MANT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sign,
    input logic [MANT_W+1:0] in_mant,
    input logic              in_sticky,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [MANT_W:0]   out_mant,
    input logic              out_up,
    input logic              out_inexact
);

    localparam int IN_W  = MANT_W + 2;
    localparam int OUT_W = MANT_W + 1;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    assert_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=> (!out_up && !out_inexact));

    assert_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_inexact == $past(in_mant[1] | in_mant[0] | in_sticky));

    assert_nearest_below_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_up);

    assert_toward_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> !out_up);

    assert_plus_inf_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10 && in_sign) |=> !out_up);

    assert_minus_inf_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11 && !in_sign) |=> !out_up);

    assert_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_mant == OUT_W'($past(in_mant[IN_W-1:2])) + OUT_W'(out_up));

    assert_up_needs_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_inexact) |-> !out_up);

endmodule

bind grs_rounder grs_rounder_chk #(.MANT_W(MANT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_mant     (in_mant),
    .in_sticky   (in_sticky),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_mant    (out_mant),
    .out_up      (out_up),
    .out_inexact (out_inexact)
);

// File: tb/grs_rounder_bench.sv
`timescale 1ns/1ps
module grs_rounder_bench;

    localparam int MW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sign = 1'b0;
    logic [MW+1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic          out_valid;
    logic [MW:0]   out_mant;
    logic          out_up;
    logic          out_inexact;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit      v;
        longint  mant;
        bit      up;
        bit      inx;
        int      md;
    } exp_t;

    exp_t pend[$];

    always #2.5 clk = ~clk;

    grs_rounder #(.MANT_W(MW)) u_grs_rounder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_mode(in_mode),
        .out_valid(out_valid), .out_mant(out_mant), .out_up(out_up),
        .out_inexact(out_inexact)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Behavioural prediction from the requirement text.
    function automatic exp_t predict(input bit v, input bit s, input longint m, input bit st, input int md);
        exp_t e;
        longint kept = m / 4;
        bit g = ((m / 2) % 2) == 1;
        bit r = (m % 2) == 1;
        bit odd = (kept % 2) == 1;
        e.v = v;
        e.md = md;
        e.inx = g || r || st;
        if (md == 0)      e.up = g && (r || st || odd);
        else if (md == 1) e.up = 1'b0;
        else if (md == 2) e.up = e.inx && !s;
        else              e.up = e.inx && s;
        e.mant = kept + (e.up ? 1 : 0);
        return e;
    endfunction

    task automatic compare();
        exp_t e;
        string rq;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        check(out_valid == e.v, "R1 valid", longint'(out_valid), longint'(e.v));
        if (!e.v) return;
        check(longint'(out_mant) == e.mant, "R8 mantissa", longint'(out_mant), e.mant);
        check(out_inexact == e.inx, e.inx ? "R3 inexact" : "R2 exact", longint'(out_inexact), longint'(e.inx));
        case (e.md)
            0: rq = "R4 up (nearest)";
            1: rq = "R5 up (zero)";
            2: rq = "R6 up (+inf)";
            default: rq = "R7 up (-inf)";
        endcase
        check(out_up == e.up, rq, longint'(out_up), longint'(e.up));
        check(!(out_up && !out_inexact), "R9 up only when inexact", longint'(out_up), 0);
    endtask

    task automatic step(input bit v, input bit s, input longint m, input bit st, input int md);
        @(negedge clk);
        compare();
        in_valid  = v;
        in_sign   = s;
        in_mant   = (MW+2)'(m);
        in_sticky = st;
        in_mode   = 2'(md);
        pend.push_back(predict(v, s, m, st, md));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        longint ones;
        ones = (longint'(1) << MW) - 1;
        // Reset state, R1
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_mant == 0 && out_up == 0 && out_inexact == 0,
              "R1 reset state", longint'(out_mant), 0);
        rst_n = 1'b1;

        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 2; s++) begin
                step(1, s[0], (longint'(5) << 2) | 0, 0, md);  // exact, R2
                step(1, s[0], (longint'(4) << 2) | 2, 0, md);  // tie, even LSB
                step(1, s[0], (longint'(5) << 2) | 2, 0, md);  // tie, odd LSB
                step(1, s[0], (longint'(4) << 2) | 3, 0, md);  // above half
                step(1, s[0], (longint'(4) << 2) | 1, 0, md);  // round only
                step(1, s[0], (longint'(4) << 2) | 0, 1, md);  // sticky only
                step(1, s[0], (longint'(4) << 2) | 2, 1, md);  // tie broken by sticky
                step(1, s[0], (ones << 2) | 2, 0, md);         // odd tie, carry to 2.0, R8
                step(1, s[0], (ones << 2) | 1, 0, md);         // carry in directed modes
                step(1, s[0], ones << 2, 0, md);               // all ones exact
                step(0, s[0], 0, 0, md);                       // idle gap, R1
            end
        end

        for (int k = 0; k < 600; k++) begin
            longint m;
            m = (longint'($urandom) << 32 | longint'($urandom)) & ((longint'(1) << (MW+2)) - 1);
            if (k % 7 == 0) m = m | (ones << 2);
            step(($urandom % 5) != 0, $urandom % 2, m, $urandom % 2, $urandom % 4);
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule